// File: doc/BRIEF.md
# Floating-Point Branch Next-PC Unit

This unit sits in the fetch-redirect path of a processor with delayed branches, where every control transfer has one delay-slot instruction after it. Each cycle it can take one instruction word with the current program counter and next program counter. If the word is a branch on floating-point condition codes, the unit decodes it and produces the new counter pair. It also reports whether the delay-slot instruction must be squashed.

Two branch formats are handled. The short format carries a 22-bit word displacement and always tests condition-code set 0. The predicted format is legal only in 64-bit mode. It carries a 19-bit word displacement and names one of four condition-code sets.

The unit also raises traps for the cases where no branch may happen: the floating-point unit is disabled, a coprocessor branch is seen, or the predicted format is used in 32-bit mode. An address-mask mode truncates the computed target to 32 bits. All results are registered, so they appear one clock after the request.

Top module: `fbr_npc_unit`

## Requirements
- R1: A word is claimed (claim_o=1) only if bits 31:30 are 00 and bits 24:22 are 110 (short), 101 (predicted) or 111 (coprocessor). Any other word gives claim_o=0, pc_o=npc_i, npc_o=npc_i+4, annul_o=0 and no trap.
- R2: The target is pc_i plus the sign-extended displacement times 4. The short format takes its displacement from bits 21:0 and the predicted format from bits 18:0.
- R3: When amask_i=1, bits above bit 31 of the target are cleared. When amask_i=0, the full-width sum is used.
- R4: Condition 0 (bits 28:25), annul bit 29 clear: pc_o=npc_i and npc_o=npc_i+4. With bit 29 set: pc_o=npc_i+4, npc_o=npc_i+8 and annul_o=1.
- R5: Condition 8, annul clear: pc_o=npc_i and npc_o=target. Annul set: pc_o=target, npc_o=target+4 and annul_o=1.
- R6: For any other condition that evaluates true, pc_o=npc_i, npc_o=target and annul_o=0, whatever the annul bit is.
- R7: For a false condition with the annul bit set: pc_o=npc_i+4, npc_o=npc_i+8 and annul_o=1. With the annul bit clear: pc_o=npc_i and npc_o=npc_i+4.
- R8: A 2-bit code means 0=equal, 1=less, 2=greater, 3=unordered. Conditions 1..7 accept these sets: 1 {L,G,U}, 2 {L,G}, 3 {L,U}, 4 {L}, 5 {G,U}, 6 {G}, 7 {U}. Condition 8+k accepts the complement of the set for k.
- R9: Set k is fcc_i[2k+1:2k]. The short format always uses set 0. The predicted format uses the set named by bits 21:20, and bit 19 has no effect.
- R10: With fpu_en_i=0, a short or predicted branch raises trap_fpdis_o, and pc_o/npc_o repeat pc_i/npc_i.
- R11: The coprocessor form raises trap_nocp_o in 32-bit mode and trap_ill_o in 64-bit mode, whatever fpu_en_i is, with the counters held.
- R12: The predicted form with mode64_i=0 raises trap_ill_o with the counters held, ahead of the FPU check.
- R13: Results register on the clock edge that samples in_valid=1. out_valid_o follows in_valid one cycle later, and other outputs hold while in_valid=0. Synchronous reset clears every output, and at most one trap is ever high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| insn_i | input | 32 | Instruction word |
| pc_i | input | ADDR_W | Current program counter |
| npc_i | input | ADDR_W | Current next program counter |
| fcc_i | input | NUM_SETS*2 | Packed floating-point condition-code sets |
| fpu_en_i | input | 1 | Floating-point unit enabled |
| mode64_i | input | 1 | 64-bit mode |
| amask_i | input | 1 | Truncate target to 32 bits |
| out_valid_o | output | 1 | Result valid |
| claim_o | output | 1 | Word was a floating-point or coprocessor branch |
| pc_o | output | ADDR_W | New program counter |
| npc_o | output | ADDR_W | New next program counter |
| annul_o | output | 1 | Delay-slot instruction is squashed |
| trap_fpdis_o | output | 1 | FPU-disabled trap |
| trap_nocp_o | output | 1 | No-coprocessor trap |
| trap_ill_o | output | 1 | Illegal-instruction trap |

## Verification
Each of the two unconditional conditions is run with the annul bit both clear and set, because the annul bit has the opposite effect in these two cases. Conditional branches are run taken and not taken with both annul values. This separates the "annul only when untaken" rule from the unconditional rules. Condition-set selection is tested by giving the four sets different codes, so that reading the wrong set changes the outcome. Negative displacements in both formats, and a target whose sum carries past bit 31 under address masking, check the sign extension and the truncation.

// File: rtl/fbr_pkg.sv
package fbr_pkg;
  localparam int INSN_W = 32;
  localparam int DISP_W = 22;

  typedef enum logic [1:0] {
    FORM_NONE,
    FORM_SHORT,
    FORM_PRED,
    FORM_COPROC
  } form_e;

  // Accept mask indexed by code value: bit0 equal, bit1 less, bit2 greater, bit3 unordered
  function automatic logic [3:0] cond_accept(input logic [3:0] cond);
    logic [3:0] base;
    case (cond[2:0])
      3'd0: base = 4'b0000;
      3'd1: base = 4'b1110;
      3'd2: base = 4'b0110;
      3'd3: base = 4'b1010;
      3'd4: base = 4'b0010;
      3'd5: base = 4'b1100;
      3'd6: base = 4'b0100;
      default: base = 4'b1000;
    endcase
    return cond[3] ? ~base : base;
  endfunction
endpackage

// File: rtl/fbr_decode.sv
module fbr_decode
  import fbr_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output form_e             form,
  output logic              annul_bit,
  output logic [3:0]        cond,
  output logic [1:0]        cc_sel,
  output logic [DISP_W-1:0] disp
);
  logic [1:0] op;
  logic [2:0] sub;

  assign op        = insn[31:30];
  assign sub       = insn[24:22];
  assign annul_bit = insn[29];
  assign cond      = insn[28:25];

  always_comb begin
    form   = FORM_NONE;
    cc_sel = 2'd0;
    disp   = insn[21:0];
    if (op == 2'b00) begin
      case (sub)
        3'b110: form = FORM_SHORT;
        3'b101: begin
          form   = FORM_PRED;
          cc_sel = insn[21:20];
          disp   = {{(DISP_W-19){insn[18]}}, insn[18:0]};
        end
        3'b111: form = FORM_COPROC;
        default: form = FORM_NONE;
      endcase
    end
  end
endmodule

// File: rtl/fbr_cond_eval.sv
module fbr_cond_eval
  import fbr_pkg::*;
#(
  parameter int NUM_SETS = 4,
  parameter int CC_W     = 2,
  localparam int SEL_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic [NUM_SETS*CC_W-1:0] fcc,
  input  logic [SEL_W-1:0]         sel,
  input  logic [3:0]               cond,
  output logic                     hit
);
  logic [CC_W-1:0] sets [NUM_SETS];

  for (genvar g = 0; g < NUM_SETS; g++) begin : g_unpack
    assign sets[g] = fcc[g*CC_W +: CC_W];
  end

  logic [CC_W-1:0] code;
  logic [3:0]      accept;

  assign code   = sets[sel];
  assign accept = cond_accept(cond);
  assign hit    = accept[code];
endmodule

// File: rtl/fbr_target.sv
module fbr_target
  import fbr_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int MASK_W = 32
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [DISP_W-1:0] disp,
  input  logic              amask,
  output logic [ADDR_W-1:0] target
);
  logic [ADDR_W-1:0] offs;
  logic [ADDR_W-1:0] sum;

  assign offs = {{(ADDR_W-DISP_W-2){disp[DISP_W-1]}}, disp, 2'b00};
  assign sum  = pc + offs;

  if (ADDR_W > MASK_W) begin : g_mask
    assign target = amask ? {{(ADDR_W-MASK_W){1'b0}}, sum[MASK_W-1:0]} : sum;
  end else begin : g_nomask
    logic unused_amask;
    assign unused_amask = amask;
    assign target = sum;
  end
endmodule

// File: rtl/fbr_npc_unit.sv
module fbr_npc_unit
  import fbr_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int NUM_SETS = 4,
  parameter int CC_W     = 2,
  localparam int FCC_W   = NUM_SETS * CC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [31:0]       insn_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] npc_i,
  input  logic [FCC_W-1:0]  fcc_i,
  input  logic              fpu_en_i,
  input  logic              mode64_i,
  input  logic              amask_i,
  output logic              out_valid_o,
  output logic              claim_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] npc_o,
  output logic              annul_o,
  output logic              trap_fpdis_o,
  output logic              trap_nocp_o,
  output logic              trap_ill_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  form_e             form;
  logic              abit;
  logic [3:0]        cond;
  logic [1:0]        cc_sel;
  logic [DISP_W-1:0] disp;
  logic              hit;
  logic [ADDR_W-1:0] target;

  fbr_decode u_dec (
    .insn(insn_i), .form(form), .annul_bit(abit),
    .cond(cond), .cc_sel(cc_sel), .disp(disp)
  );

  fbr_cond_eval #(.NUM_SETS(4), .CC_W(CC_W)) u_eval (
    .fcc(fcc_i), .sel(cc_sel), .cond(cond), .hit(hit)
  );

  fbr_target #(.ADDR_W(ADDR_W)) u_tgt (
    .pc(pc_i), .disp(disp), .amask(amask_i), .target(target)
  );

  logic              n_claim, n_annul, n_fpdis, n_nocp, n_ill;
  logic [ADDR_W-1:0] n_pc, n_npc;

  always_comb begin
    n_claim = (form != FORM_NONE);
    n_pc    = npc_i;
    n_npc   = npc_i + STEP;
    n_annul = 1'b0;
    n_fpdis = 1'b0;
    n_nocp  = 1'b0;
    n_ill   = 1'b0;
    if (form == FORM_COPROC) begin
      n_ill  = mode64_i;
      n_nocp = !mode64_i;
      n_pc   = pc_i;
      n_npc  = npc_i;
    end else if (form == FORM_PRED && !mode64_i) begin
      n_ill = 1'b1;
      n_pc  = pc_i;
      n_npc = npc_i;
    end else if (n_claim && !fpu_en_i) begin
      n_fpdis = 1'b1;
      n_pc    = pc_i;
      n_npc   = npc_i;
    end else if (n_claim) begin
      if (cond == 4'd8 && abit) begin
        n_pc    = target;
        n_npc   = target + STEP;
        n_annul = 1'b1;
      end else if (hit) begin
        n_npc = target;
      end else if (abit) begin
        n_pc    = npc_i + STEP;
        n_npc   = npc_i + (STEP << 1);
        n_annul = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_o  <= 1'b0;
      claim_o      <= 1'b0;
      pc_o         <= '0;
      npc_o        <= '0;
      annul_o      <= 1'b0;
      trap_fpdis_o <= 1'b0;
      trap_nocp_o  <= 1'b0;
      trap_ill_o   <= 1'b0;
    end else begin
      out_valid_o <= in_valid;
      if (in_valid) begin
        claim_o      <= n_claim;
        pc_o         <= n_pc;
        npc_o        <= n_npc;
        annul_o      <= n_annul;
        trap_fpdis_o <= n_fpdis;
        trap_nocp_o  <= n_nocp;
        trap_ill_o   <= n_ill;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid_o); // R13
  AST_TRAP_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({trap_fpdis_o, trap_nocp_o, trap_ill_o})); // R13
  AST_TRAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    in_valid && fpu_en_i == 1'b0 && insn_i[31:30] == 2'b00 && insn_i[24:22] == 3'b110
    |=> pc_o == $past(pc_i) && npc_o == $past(npc_i)); // R10
  AST_NEVER_SEQ: assert property (@(posedge clk) disable iff (rst)
    in_valid && fpu_en_i && insn_i[31:30] == 2'b00 && insn_i[24:22] == 3'b110 && insn_i[28:25] == 4'd0
    |=> claim_o && npc_o == pc_o + STEP && annul_o == $past(insn_i[29])); // R4
  AST_ALWAYS_ANNUL: assert property (@(posedge clk) disable iff (rst)
    in_valid && fpu_en_i && insn_i[31:29] == 3'b001 && insn_i[24:22] == 3'b110 && insn_i[28:25] == 4'd8
    |=> annul_o && npc_o == pc_o + STEP); // R5
  AST_COPROC_TRAP: assert property (@(posedge clk) disable iff (rst)
    in_valid && insn_i[31:30] == 2'b00 && insn_i[24:22] == 3'b111
    |=> trap_nocp_o != $past(mode64_i) && trap_ill_o == $past(mode64_i)); // R11
  AST_PRED32_ILL: assert property (@(posedge clk) disable iff (rst)
    in_valid && !mode64_i && insn_i[31:30] == 2'b00 && insn_i[24:22] == 3'b101
    |=> trap_ill_o && !trap_fpdis_o); // R12
  AST_ANNUL_CLEAN: assert property (@(posedge clk) disable iff (rst)
    annul_o |-> claim_o && !trap_fpdis_o && !trap_nocp_o && !trap_ill_o); // R7
endmodule

// File: tb/sim_fbr_npc_unit.sv
module sim_fbr_npc_unit;
  localparam int AW = 64;
  localparam int N  = 22;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [31:0]   insn = '0;
  logic [AW-1:0] pc = '0, npc = '0;
  logic [7:0]    fcc = '0;
  logic          fpu_en = 1'b1, mode64 = 1'b0, amask = 1'b0;
  logic          out_valid, claim, annul, t_fpdis, t_nocp, t_ill;
  logic [AW-1:0] pc_o, npc_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  fbr_npc_unit #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .insn_i(insn),
    .pc_i(pc), .npc_i(npc), .fcc_i(fcc), .fpu_en_i(fpu_en),
    .mode64_i(mode64), .amask_i(amask), .out_valid_o(out_valid),
    .claim_o(claim), .pc_o(pc_o), .npc_o(npc_o), .annul_o(annul),
    .trap_fpdis_o(t_fpdis), .trap_nocp_o(t_nocp), .trap_ill_o(t_ill)
  );

  // ctl = {fpu_en, mode64, amask}; flg = {claim, annul, fpdis, nocp, ill}; pc/npc in = 0x1000/0x1004
  localparam logic [31:0] T_INSN [N] = '{
    32'h01800005, 32'h21800005, 32'h11800010, 32'h31800010, 32'h13800010, 32'h33800010,
    32'h13800010, 32'h33800010, 32'h31BFFFFF, 32'h0F680020, 32'h2F500020, 32'h3147FFF0,
    32'h31400010, 32'h31800010, 32'h01C00000, 32'h01C00000, 32'h01C00000, 32'h40000000,
    32'h17800010, 32'h1D800010, 32'h00800000, 32'h13800010};
  localparam logic [7:0] T_FCC [N] = '{
    8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h02, 8'h00, 8'h00, 8'h30, 8'h30,
    8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h03, 8'h03, 8'h00, 8'hFC};
  localparam logic [2:0] T_CTL [N] = '{
    3'b100, 3'b100, 3'b100, 3'b100, 3'b100, 3'b100, 3'b100, 3'b100, 3'b100, 3'b110, 3'b110,
    3'b110, 3'b100, 3'b000, 3'b100, 3'b110, 3'b000, 3'b100, 3'b100, 3'b100, 3'b100, 3'b100};
  localparam logic [15:0] T_PC [N] = '{
    16'h1004, 16'h1008, 16'h1004, 16'h1040, 16'h1004, 16'h1008, 16'h1004, 16'h1004,
    16'h0FFC, 16'h1004, 16'h1008, 16'h0FC0, 16'h1000, 16'h1000, 16'h1000, 16'h1000,
    16'h1000, 16'h1004, 16'h1004, 16'h1004, 16'h1004, 16'h1004};
  localparam logic [15:0] T_NPC [N] = '{
    16'h1008, 16'h100C, 16'h1040, 16'h1044, 16'h1040, 16'h100C, 16'h1008, 16'h1040,
    16'h1000, 16'h1080, 16'h100C, 16'h0FC4, 16'h1004, 16'h1004, 16'h1004, 16'h1004,
    16'h1004, 16'h1008, 16'h1008, 16'h1040, 16'h1008, 16'h1040};
  localparam logic [4:0] T_FLG [N] = '{
    5'b10000, 5'b11000, 5'b10000, 5'b11000, 5'b10000, 5'b11000, 5'b10000, 5'b10000,
    5'b11000, 5'b10000, 5'b11000, 5'b11000, 5'b10001, 5'b10100, 5'b10010, 5'b10001,
    5'b10010, 5'b00000, 5'b10000, 5'b10000, 5'b00000, 5'b10000};
  localparam logic [23:0] T_REQ [N] = '{
    "R4 ", "R4 ", "R5 ", "R5 ", "R6 ", "R7 ", "R7 ", "R6 ", "R2 ", "R9 ", "R9 ",
    "R2 ", "R12", "R10", "R11", "R11", "R11", "R1 ", "R8 ", "R8 ", "R1 ", "R9 "};

  task automatic check(input string req, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] w, input logic [AW-1:0] p, input logic [AW-1:0] np,
                       input logic [7:0] f, input logic [2:0] ctl);
    @(negedge clk);
    insn = w; pc = p; npc = np; fcc = f;
    {fpu_en, mode64, amask} = ctl;
    in_valid = 1'b1;
    @(posedge clk);
    #2;
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R13", "reset valid", AW'(out_valid), 0);
    check("R13", "reset pc", pc_o, 0);
    check("R13", "reset flags", AW'({claim, annul, t_fpdis, t_nocp, t_ill}), 0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < N; i++) begin
      drive(T_INSN[i], AW'(16'h1000), AW'(16'h1004), T_FCC[i], T_CTL[i]);
      check(string'(T_REQ[i]), "valid", AW'(out_valid), 1);
      check(string'(T_REQ[i]), "pc", pc_o, AW'(T_PC[i]));
      check(string'(T_REQ[i]), "npc", npc_o, AW'(T_NPC[i]));
      check(string'(T_REQ[i]), "flags", AW'({claim, annul, t_fpdis, t_nocp, t_ill}), AW'(T_FLG[i]));
    end

    // R3: address mask clears upper bits, including a carry out of bit 31
    drive(32'h31800010, 64'h1_0000_1000, 64'h1_0000_1004, 8'h00, 3'b101);
    check("R3", "masked pc", pc_o, 64'h1040);
    check("R3", "masked npc", npc_o, 64'h1044);
    drive(32'h31800010, 64'h1_0000_1000, 64'h1_0000_1004, 8'h00, 3'b100);
    check("R3", "unmasked pc", pc_o, 64'h1_0000_1040);
    drive(32'h31800010, 64'hFFFF_FFF0, 64'hFFFF_FFF4, 8'h00, 3'b101);
    check("R3", "carry masked pc", pc_o, 64'h30);
    check("R3", "carry masked npc", npc_o, 64'h34);

    // R13: outputs hold while in_valid is low
    @(negedge clk);
    insn = 32'h01C00000; pc = 64'h5000; npc = 64'h5004;
    @(posedge clk);
    #2;
    check("R13", "idle valid", AW'(out_valid), 0);
    check("R13", "idle hold pc", pc_o, 64'h30);
    check("R13", "idle hold trap", AW'(t_nocp), 0);

    // R13: reset mid-run clears outputs
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #2;
    check("R13", "rerun reset pc", pc_o, 0);
    @(negedge clk);
    rst = 1'b0;

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule